// File: doc/BRIEF.md
# Input Capture Delay Glitch Filter

This block sits ahead of a timer input-capture channel and stops short pulses on the capture pin from reaching it. The raw pin is first synchronised to the module clock. A selectable edge type (rising, falling or both) then starts a delay count of 256, 512 or 1024 module-clock cycles. When the count ends, the block compares the synchronised pin with the level it held just before the edge. A one-cycle qualified strobe is issued only if the level has flipped. The delay can also be set to bypass, in which case every selected edge produces the strobe straight away.

The edge select and the delay select come from a control register outside this block and may change at any time. Changing the delay select while a count is running cancels that count. Edges that arrive while a count is running are dropped. Correct filtering is only promised when active edges are spaced further apart than the selected delay.

Top module: `icap_delay_filter`

## Requirements
- R1: `dly_sel_i` picks the delay: 2'b00 is bypass, 2'b01 is 256 cycles, 2'b10 is 512 cycles and 2'b11 is 1024 cycles. With a non-zero code, a qualified strobe comes exactly that many cycles later than it would in bypass.
- R2: `edge_sel_i` picks the active edge: 2'b00 means none, 2'b01 means rising, 2'b10 means falling and 2'b11 means both. Edges that are not selected never produce a strobe and never start a count.
- R3: In bypass, a selected pin transition driven before clock edge t gives `strobe_o` high in the cycle after clock edge t+2. This accounts for two synchroniser flops and one output register.
- R4: With a delay selected, the strobe is issued when the synchronised pin at the end of the count is the opposite of its level before the edge.
- R5: If the pin has returned to its pre-edge level by the end of the count, no strobe is produced.
- R6: Edges that arrive while a count is running are ignored. They do not restart the count and do not add a strobe.
- R7: A change of `dly_sel_i` while a count is running aborts the count without a strobe.
- R8: Every strobe is exactly one clock cycle wide.
- R9: The counter clears itself when a count ends. A later qualified edge is then filtered with the full delay.
- R10: While `rst_n` is low (synchronous reset), `strobe_o` is 0 and the filter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Raw, asynchronous capture pin |
| edge_sel_i | input | 2 | Active-edge select (off / rising / falling / both) |
| dly_sel_i | input | 2 | Delay select (bypass / 256 / 512 / 1024) |
| strobe_o | output | 1 | One-cycle qualified capture strobe |

## Verification
A stuck or mis-loaded counter shows at the port as a strobe at the wrong cycle, off by the counting error, or as no strobe at all once the selected delay has passed. A wrong stored pre-edge level turns a glitch into a strobe, or a real edge into silence, at exactly 3+N cycles after the pin change. A state machine that fails to return to idle shows up one test later, as a missing strobe for the next qualified edge. The scoreboard therefore checks every strobe against its exact expected cycle, and after each stimulus it checks that no expected strobe is still pending.

// File: rtl/icap_filter_pkg.sv
// Shared types for the input capture delay glitch filter.
package icap_filter_pkg;

    // Active-edge selection codes
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Delay selection codes
    typedef enum logic [1:0] {
        DLY_BYPASS = 2'b00,
        DLY_X1     = 2'b01,
        DLY_X2     = 2'b10,
        DLY_X4     = 2'b11
    } dly_sel_e;

    // Qualifier state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } qual_state_e;

endpackage

// File: rtl/icap_sync.sv
// Multi-flop synchroniser for the raw capture pin.
// Assumes: the pin is asynchronous and STAGES >= 2. Reset value is 0.
module icap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first stage samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/icap_edge_detect.sv
// Detects the selected edge type on the synchronised pin.
// Gives the pre-edge level as a side output (the level one cycle before the change).
// Assumes: sync_i is already in the clk domain.
module icap_edge_detect
    import icap_filter_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_i,
    input  logic [1:0] edge_sel_i,
    output logic       edge_o,
    output logic       pre_level_o
);
    logic prev_q;
    logic rise, fall;

    // keep the previous synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_i;
    end

    // classify the transition and gate it by the edge select
    always_comb begin
        rise = sync_i & ~prev_q;
        fall = ~sync_i & prev_q;
        unique case (edge_sel_e'(edge_sel_i))
            EDGE_RISE: edge_o = rise;
            EDGE_FALL: edge_o = fall;
            EDGE_BOTH: edge_o = rise | fall;
            default:   edge_o = 1'b0;
        endcase
    end

    assign pre_level_o = prev_q;

    // R2: with the edge select off, nothing is detected
    assert_off_no_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel_i == 2'b00) |-> !edge_o);

    // R2: a detected edge always reflects a real level change
    assert_edge_is_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |-> (sync_i != prev_q));
endmodule

// File: rtl/icap_delay_qual.sv
// Delay counter and level qualifier.
// Bypass issues the strobe on the cycle after the edge. Otherwise it counts the
// selected number of cycles and then rechecks the pin against the pre-edge level.
// Assumes: the active edge spacing is longer than the selected delay. Edges during
// a count are dropped. A delay-select change during a count aborts it.
module icap_delay_qual
    import icap_filter_pkg::*;
#(
    parameter int BASE_DELAY = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       edge_i,
    input  logic       pre_level_i,
    input  logic       sync_i,
    input  logic [1:0] dly_sel_i,
    output logic       strobe_o
);
    localparam int LIM_W = $clog2(BASE_DELAY * 4) + 1;
    localparam logic [LIM_W-1:0] LIM1 = LIM_W'(BASE_DELAY);
    localparam logic [LIM_W-1:0] LIM2 = LIM_W'(BASE_DELAY * 2);
    localparam logic [LIM_W-1:0] LIM4 = LIM_W'(BASE_DELAY * 4);

    qual_state_e      state_q;
    logic [LIM_W-1:0] cnt_q;
    logic [LIM_W-1:0] lim_q;
    logic [LIM_W-1:0] lim_d;
    logic [1:0]       dly_q;
    logic             pre_q;
    logic             bypass, running, abort, done, start;

    // translate the delay code into a cycle count
    always_comb begin
        unique case (dly_sel_e'(dly_sel_i))
            DLY_X1:  lim_d = LIM1;
            DLY_X2:  lim_d = LIM2;
            DLY_X4:  lim_d = LIM4;
            default: lim_d = '0;
        endcase
    end

    // control decode
    always_comb begin
        bypass  = (dly_sel_i == 2'b00);
        running = (state_q == ST_RUN);
        abort   = running && (dly_sel_i != dly_q);
        done    = running && !abort && (cnt_q == lim_q - LIM_W'(1));
        start   = !running && edge_i && !bypass;
    end

    // remember the delay code so changes can be seen
    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= 2'b00;
        else        dly_q <= dly_sel_i;
    end

    // state, counter and captured pre-edge level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            lim_q   <= '0;
            pre_q   <= 1'b0;
        end else if (start) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
            lim_q   <= lim_d;
            pre_q   <= pre_level_i;
        end else if (abort || done) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (running) begin
            cnt_q   <= cnt_q + LIM_W'(1);
        end
    end

    // registered one-cycle qualified strobe
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_o <= 1'b0;
        else        strobe_o <= (bypass && edge_i && !running) ||
                                (done && (sync_i != pre_q));
    end

    // R1: the counter stays below the captured limit
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt_q < lim_q));

    // R3: a bypassed edge yields a strobe next cycle
    assert_bypass_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && edge_i && !running) |=> strobe_o);

    // R4: a strobe comes only from a finished count or a bypassed edge
    assert_strobe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> ($past(state_q == ST_RUN) || $past(edge_i && dly_sel_i == 2'b00)));

    // R6: an edge during a count neither restarts nor ends it
    assert_ignore_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && edge_i && !abort && !done) |=> (state_q == ST_RUN && cnt_q != '0));

    // R7: a delay-select change aborts the count without a strobe
    assert_abort_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE && !strobe_o));

    // R9: a completed count clears itself
    assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE && cnt_q == '0));
endmodule

// File: rtl/icap_delay_filter.sv
// Top of the input capture delay glitch filter: synchroniser, edge detector,
// then the delay qualifier that drives the capture strobe.
// Assumes: edge_sel_i and dly_sel_i come from a register in the clk domain.
module icap_delay_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int BASE_DELAY  = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic [1:0] edge_sel_i,
    input  logic [1:0] dly_sel_i,
    output logic       strobe_o
);
    logic pin_sync;
    logic edge_hit;
    logic pre_level;

    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    icap_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (pin_sync),
        .edge_sel_i  (edge_sel_i),
        .edge_o      (edge_hit),
        .pre_level_o (pre_level)
    );

    icap_delay_qual #(.BASE_DELAY(BASE_DELAY)) u_qual (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_i      (edge_hit),
        .pre_level_i (pre_level),
        .sync_i      (pin_sync),
        .dly_sel_i   (dly_sel_i),
        .strobe_o    (strobe_o)
    );

    // R8: a strobe never lasts two cycles while the pin is slow
    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && dly_sel_i != 2'b00) |=> !strobe_o);
endmodule

// File: tb/icap_delay_filter_tb.sv
module icap_delay_filter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic [1:0] edge_sel_i = 2'b00;
    logic [1:0] dly_sel_i = 2'b00;
    logic       strobe_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;
    int    q_cyc[$];
    string q_req[$];

    icap_delay_filter u_dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
        .edge_sel_i(edge_sel_i), .dly_sel_i(dly_sel_i), .strobe_o(strobe_o)
    );

    always #10 clk = ~clk;  // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: every strobe must match the head of the expected queue
    always @(negedge clk) begin
        if (rst_n && strobe_o) begin
            checks++;
            if (q_cyc.size() == 0) begin
                errors++;
                $display("FAIL R8/R5: unexpected strobe at cycle %0d, expected none", cyc);
            end else begin
                int    ec;
                string er;
                ec = q_cyc.pop_front();
                er = q_req.pop_front();
                if (ec != cyc) begin
                    errors++;
                    $display("FAIL %s: strobe at cycle %0d, expected %0d", er, cyc, ec);
                end
            end
        end
    end

    // driver: change the pin and optionally queue the expected strobe cycle
    task automatic drive(input logic v, input int delay, input bit expect_hit, input string req);
        @(negedge clk);
        pin_i = v;
        if (expect_hit) begin
            q_cyc.push_back(cyc + 3 + delay);
            q_req.push_back(req);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        checks++;
        if (q_cyc.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d strobe(s) missing, expected 0 pending", req, q_cyc.size());
            q_cyc.delete();
            q_req.delete();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        // R10: reset state
        idle(4);
        checks++;
        if (strobe_o !== 1'b0) begin
            errors++;
            $display("FAIL R10: strobe in reset %b, expected 0", strobe_o);
        end
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        // R3/R2: bypass, rising only
        edge_sel_i = 2'b01;
        drive(1, 0, 1, "R3"); idle(8);
        drive(0, 0, 0, "R2"); idle(8); drain("R2 rise-only");
        // R2: falling only
        edge_sel_i = 2'b10;
        drive(1, 0, 0, "R2"); idle(8);
        drive(0, 0, 1, "R2"); idle(8); drain("R2 fall-only");
        // R2: none
        edge_sel_i = 2'b00;
        drive(1, 0, 0, "R2"); idle(8);
        drive(0, 0, 0, "R2"); idle(8); drain("R2 off");
        // R2: both
        edge_sel_i = 2'b11;
        drive(1, 0, 1, "R2"); idle(8);
        drive(0, 0, 1, "R2"); idle(8); drain("R2 both");

        // R1/R4: 256, 512, 1024 delays on rising edges
        edge_sel_i = 2'b01; dly_sel_i = 2'b01; idle(3);
        drive(1, 256, 1, "R1 256"); idle(300); drain("R1 256");
        drive(0, 0, 0, "R4"); idle(10);
        dly_sel_i = 2'b10; idle(3);
        drive(1, 512, 1, "R1 512"); idle(560); drain("R1 512");
        drive(0, 0, 0, "R4"); idle(10);
        dly_sel_i = 2'b11; idle(3);
        drive(1, 1024, 1, "R4 1024"); idle(1080); drain("R4 1024");
        drive(0, 0, 0, "R4"); idle(10);

        // R4: falling edge qualified with delay
        edge_sel_i = 2'b10; dly_sel_i = 2'b01; idle(3);
        drive(1, 0, 0, "R4"); idle(10);
        drive(0, 256, 1, "R4 fall"); idle(300); drain("R4 fall");

        // R5: narrow pulse rejected
        edge_sel_i = 2'b11; idle(3);
        drive(1, 0, 0, "R5"); idle(20);
        drive(0, 0, 0, "R5"); idle(300); drain("R5 glitch");

        // R6: edges mid-count ignored, no restart
        edge_sel_i = 2'b01;
        drive(1, 256, 1, "R6"); idle(30);
        drive(0, 0, 0, "R6"); idle(30);
        drive(1, 0, 0, "R6"); idle(300); drain("R6 ignore");

        // R9: counter cleared, next edge filtered with full delay
        drive(0, 0, 0, "R9"); idle(5);
        drive(1, 256, 1, "R9"); idle(300); drain("R9 reuse");
        drive(0, 0, 0, "R9"); idle(5);

        // R7: delay change mid-count aborts
        drive(1, 0, 0, "R7"); idle(50);
        dly_sel_i = 2'b10; idle(600); drain("R7 abort");
        drive(0, 0, 0, "R7"); idle(5);
        // R7: after abort, filter works with the new delay
        drive(1, 512, 1, "R7 after"); idle(560); drain("R7 after");

        finish_run();
    end
endmodule